// File: doc/BRIEF.md
# Shared Interrupt Line Swizzle and Router

This block gathers level-sensitive interrupt requests from up to 64 devices on a shared bus. Each device can raise any of four pins (A to D, encoded 0 to 3). A pin is rotated by the device's slot number onto one of four shared interrupt lines. Each device keeps one level bit per line, so many devices can share a line. A line is active while any device bit mapped to it is set.

Four routing registers steer the lines onto a 16-input interrupt controller request vector. A routing register with its top bit set leaves its line unconnected. Two byte-wide trigger-mode registers give a 16-bit mask in which a set bit marks a controller input as level-triggered.

Request events and register writes are sampled on the rising clock edge. All outputs are combinational functions of registered state only.

Top module: `irq_swizzle_router`

## Requirements
- R1: After reset, lines_o, irq_o and level_mask_o are all zero. Every routing register starts with its disconnect bit set, which is the 0x80 value.
- R2: An event with evt_pin_i = p (0..3 for pins A..D) and slot s acts on shared line (p + s) mod 4.
- R3: An event with evt_level_i = 1 sets the level bit that device evt_dev_i holds for its line. An event with evt_level_i = 0 clears that bit. No other device's bit and no other line of the same device changes.
- R4: lines_o[n] is the OR of the level bits that all devices hold for line n.
- R5: A write with cfg_sel_i = n (0..3) loads the routing register of line n. If data bit 7 is set, line n drives no controller input. Otherwise data bits 3:0 name the controller input that line n drives. Data bits 6:4 are ignored.
- R6: Each bit of irq_o is the OR of every connected line routed to that input.
- R7: A write with cfg_sel_i = 4 loads level_mask_o[7:0]. A write with cfg_sel_i = 5 loads level_mask_o[15:8]. A set bit marks that controller input as level-triggered.
- R8: Writes with cfg_sel_i = 6 or 7 change none of the outputs.
- R9: An event or write sampled at a rising edge is visible on the outputs after that same edge, with no further cycle of delay.
- R10: The default assignment sends lines 0..3 to controller inputs 11, 9, 11 and 9, with the mask equal to 0x0A00. With that assignment, lines 0 and 2 both drive irq_o[11], and lines 1 and 3 both drive irq_o[9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Request level event strobe |
| evt_dev_i | input | 6 | Device index whose level bit is updated |
| evt_slot_i | input | 5 | Slot number of the device |
| evt_pin_i | input | 2 | Pin of the device (0..3 = A..D) |
| evt_level_i | input | 1 | New level of that pin |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | 0..3 routing register of line n, 4 mask low byte, 5 mask high byte |
| cfg_wdata_i | input | 8 | Register write data |
| lines_o | output | 4 | Shared line levels |
| irq_o | output | 16 | Controller request vector |
| level_mask_o | output | 16 | Level-trigger mask per controller input |

## Verification
The bench places two devices in different slots with different pins so that both fold onto the same line. It then releases them one at a time. A design that kept one bit per line instead of one per device would drop the line too early, and a wrong rotation would light the wrong line. It also programs routes with junk in bits 6:4, sets and clears the disconnect bit, and sends two lines to one controller input. A decoder that misses these cases would send the request to the wrong input or lose the OR. Writes to the two unused selector codes confirm that the trigger mask and the routing stay untouched. Long random runs of events and writes are then compared cycle by cycle against a bench model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_LINES    = 4;
  localparam int LINE_W       = 2;
  localparam int SEL_W        = 3;
  localparam int DIS_BIT      = 7;
  localparam int MASK_SEL_LO  = 4;
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
  parameter int SLOT_W = 5
) (
  input  logic [1:0]                        pin_i,
  input  logic [SLOT_W-1:0]                 slot_i,
  output logic [irq_router_pkg::LINE_W-1:0] line_o
);
  import irq_router_pkg::*;
  logic [SLOT_W:0] sum;
  always_comb begin
    sum    = {{(SLOT_W-1){1'b0}}, pin_i} + {1'b0, slot_i};
    line_o = LINE_W'(sum % (SLOT_W+1)'(NUM_LINES));
  end
endmodule

// File: rtl/irq_level_store.sv
module irq_level_store #(
  parameter int NUM_DEV = 64,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 upd_i,
  input  logic [DEV_W-1:0]                     dev_i,
  input  logic [irq_router_pkg::LINE_W-1:0]    line_i,
  input  logic                                 level_i,
  output logic [irq_router_pkg::NUM_LINES-1:0] lines_o
);
  import irq_router_pkg::*;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_DEV-1:0] bits_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bits_q <= '0;
      else if (upd_i && line_i == LINE_W'(l)) bits_q[dev_i] <= level_i;
    end
    assign lines_o[l] = |bits_q;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NUM_CTRL = 16,
  localparam int CTRL_W  = $clog2(NUM_CTRL),
  localparam int MASK_B  = NUM_CTRL / 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   we_i,
  input  logic [irq_router_pkg::SEL_W-1:0]       sel_i,
  input  logic [7:0]                             wdata_i,
  output logic [irq_router_pkg::NUM_LINES-1:0]   dis_o,
  output logic [irq_router_pkg::NUM_LINES*CTRL_W-1:0] tgt_o,
  output logic [NUM_CTRL-1:0]                    mask_o
);
  import irq_router_pkg::*;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dis_o[l]                   <= 1'b1;
        tgt_o[l*CTRL_W +: CTRL_W]  <= '0;
      end else if (we_i && sel_i == SEL_W'(l)) begin
        dis_o[l]                   <= wdata_i[DIS_BIT];
        tgt_o[l*CTRL_W +: CTRL_W]  <= wdata_i[CTRL_W-1:0];
      end
    end
  end

  for (genvar b = 0; b < MASK_B; b++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_o[b*8 +: 8] <= '0;
      else if (we_i && sel_i == SEL_W'(MASK_SEL_LO + b)) mask_o[b*8 +: 8] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux #(
  parameter int NUM_CTRL = 16,
  localparam int CTRL_W  = $clog2(NUM_CTRL)
) (
  input  logic [irq_router_pkg::NUM_LINES-1:0]        lines_i,
  input  logic [irq_router_pkg::NUM_LINES-1:0]        dis_i,
  input  logic [irq_router_pkg::NUM_LINES*CTRL_W-1:0] tgt_i,
  output logic [NUM_CTRL-1:0]                         irq_o
);
  import irq_router_pkg::*;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_in
    always_comb begin
      irq_o[k] = 1'b0;
      for (int l = 0; l < NUM_LINES; l++)
        if (lines_i[l] && !dis_i[l] && tgt_i[l*CTRL_W +: CTRL_W] == CTRL_W'(k))
          irq_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router #(
  parameter int NUM_DEV  = 64,
  parameter int SLOT_W   = 5,
  parameter int NUM_CTRL = 16,
  localparam int DEV_W   = $clog2(NUM_DEV),
  localparam int CTRL_W  = $clog2(NUM_CTRL)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_valid_i,
  input  logic [DEV_W-1:0]    evt_dev_i,
  input  logic [SLOT_W-1:0]   evt_slot_i,
  input  logic [1:0]          evt_pin_i,
  input  logic                evt_level_i,
  input  logic                cfg_we_i,
  input  logic [2:0]          cfg_sel_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [3:0]          lines_o,
  output logic [NUM_CTRL-1:0] irq_o,
  output logic [NUM_CTRL-1:0] level_mask_o
);
  import irq_router_pkg::*;

  logic [LINE_W-1:0]           evt_line;
  logic [NUM_LINES-1:0]        route_dis;
  logic [NUM_LINES*CTRL_W-1:0] route_tgt;

  irq_swizzle #(.SLOT_W(SLOT_W)) u_swz (
    .pin_i (evt_pin_i), .slot_i(evt_slot_i), .line_o(evt_line)
  );

  irq_level_store #(.NUM_DEV(NUM_DEV)) u_store (
    .clk_i, .rst_ni,
    .upd_i  (evt_valid_i), .dev_i(evt_dev_i), .line_i(evt_line),
    .level_i(evt_level_i), .lines_o(lines_o)
  );

  irq_route_regs #(.NUM_CTRL(NUM_CTRL)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .dis_o(route_dis), .tgt_o(route_tgt), .mask_o(level_mask_o)
  );

  irq_route_mux #(.NUM_CTRL(NUM_CTRL)) u_mux (
    .lines_i(lines_o), .dis_i(route_dis), .tgt_i(route_tgt), .irq_o(irq_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_DEV  = 64,
  parameter int SLOT_W   = 5,
  parameter int NUM_CTRL = 16,
  localparam int DEV_W   = $clog2(NUM_DEV)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                evt_valid_i,
  input logic [DEV_W-1:0]    evt_dev_i,
  input logic [SLOT_W-1:0]   evt_slot_i,
  input logic [1:0]          evt_pin_i,
  input logic                evt_level_i,
  input logic                cfg_we_i,
  input logic [2:0]          cfg_sel_i,
  input logic [7:0]          cfg_wdata_i,
  input logic [3:0]          lines_o,
  input logic [NUM_CTRL-1:0] irq_o,
  input logic [NUM_CTRL-1:0] level_mask_o
);
  logic [1:0] exp_line;
  assign exp_line = 2'((32'(evt_pin_i) + 32'(evt_slot_i)) % 4);

  assert_line_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_level_i) |=> lines_o[$past(exp_line)]);

  assert_idle_lines_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lines_o == 4'b0) |-> (irq_o == '0));

  assert_mask_low_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == 3'd4) |=> (level_mask_o[7:0] == $past(cfg_wdata_i)));

  assert_unused_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i[2:1] == 2'b11) |=> $stable(level_mask_o));
endmodule

bind irq_swizzle_router irq_router_chk #(
  .NUM_DEV(NUM_DEV), .SLOT_W(SLOT_W), .NUM_CTRL(NUM_CTRL)
) u_chk (.*);

// File: tb/irq_swizzle_router_test.sv
`timescale 1ns/1ps
module irq_swizzle_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [5:0]  evt_dev = '0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic        evt_level = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  lines;
  logic [15:0] irq;
  logic [15:0] mask;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_bits [4];
  logic        m_dis  [4];
  logic [3:0]  m_tgt  [4];
  logic [15:0] m_mask;

  always #2.5 clk = ~clk;

  irq_swizzle_router uut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_dev_i(evt_dev), .evt_slot_i(evt_slot),
    .evt_pin_i(evt_pin), .evt_level_i(evt_level),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .lines_o(lines), .irq_o(irq), .level_mask_o(mask)
  );

  function automatic logic [3:0] exp_lines();
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = |m_bits[l];
    return r;
  endfunction

  function automatic logic [15:0] exp_irq();
    logic [15:0] r = '0;
    logic [3:0]  ln = exp_lines();
    for (int l = 0; l < 4; l++) if (ln[l] && !m_dis[l]) r[m_tgt[l]] = 1'b1;
    return r;
  endfunction

  task automatic model_reset();
    for (int l = 0; l < 4; l++) begin m_bits[l] = '0; m_dis[l] = 1'b1; m_tgt[l] = '0; end
    m_mask = '0;
  endtask

  task automatic check(string tag);
    n_chk++;
    if (lines !== exp_lines()) begin
      n_fail++; $display("FAIL %s lines_o got %h exp %h", tag, lines, exp_lines());
    end else if (irq !== exp_irq()) begin
      n_fail++; $display("FAIL %s irq_o got %h exp %h", tag, irq, exp_irq());
    end else if (mask !== m_mask) begin
      n_fail++; $display("FAIL %s level_mask_o got %h exp %h", tag, mask, m_mask);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, outputs settle after it
  task automatic step(input logic v, input int dev, input int slot, input int pin,
                      input logic lvl, input logic we, input int sel, input int data);
    int ln;
    @(negedge clk);
    evt_valid = v; evt_dev = 6'(dev); evt_slot = 5'(slot); evt_pin = 2'(pin);
    evt_level = lvl; cfg_we = we; cfg_sel = 3'(sel); cfg_wdata = 8'(data);
    @(posedge clk);
    if (v) begin
      ln = (pin + slot) % 4;
      m_bits[ln][dev] = lvl;
    end
    if (we) begin
      if (sel < 4) begin m_dis[sel] = data[7]; m_tgt[sel] = 4'(data); end
      else if (sel == 4) m_mask[7:0] = 8'(data);
      else if (sel == 5) m_mask[15:8] = 8'(data);
    end
    #1;
    evt_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic ev(int dev, int slot, int pin, logic lvl);
    step(1'b1, dev, slot, pin, lvl, 1'b0, 0, 0);
  endtask

  task automatic wr(int sel, int data);
    step(1'b0, 0, 0, 0, 1'b0, 1'b1, sel, data);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1; check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check("R1 after release");

    // R2: slot 1 pin A -> line 1; lines_o changes right after the edge (R9)
    ev(5, 1, 0, 1'b1); check("R2 R9 slot1 pinA");
    if (lines !== 4'b0010) begin n_fail++; $display("FAIL R2 lines got %b exp 0010", lines); end
    n_chk++;
    // R2/R4: slot 3 pin C also lands on line 1
    ev(6, 3, 2, 1'b1); check("R2 R4 slot3 pinC");
    ev(5, 1, 0, 1'b0); check("R3 one device released, line held");
    if (lines !== 4'b0010) begin n_fail++; $display("FAIL R3 lines got %b exp 0010", lines); end
    n_chk++;
    // R3: same device on another line leaves line 1 bit alone
    ev(6, 3, 3, 1'b1); check("R3 other line same device");
    ev(6, 3, 2, 1'b0); check("R3 clear line1");
    ev(6, 3, 3, 1'b0); check("R4 all clear");

    // R5 routing
    ev(9, 0, 1, 1'b1);
    wr(1, 8'h05); check("R5 route line1 to 5");
    if (irq !== 16'h0020) begin n_fail++; $display("FAIL R5 irq got %h exp 0020", irq); end
    n_chk++;
    wr(1, 8'h75); check("R5 bits 6:4 ignored");
    wr(1, 8'h85); check("R5 disconnected");
    if (irq !== 16'h0000) begin n_fail++; $display("FAIL R5 irq got %h exp 0000", irq); end
    n_chk++;

    // R10 default assignment, R7 mask bytes
    wr(0, 11); wr(1, 9); wr(2, 11); wr(3, 9);
    wr(4, 8'h00); wr(5, 8'h0A); check("R7 R10 default mask");
    if (mask !== 16'h0A00) begin n_fail++; $display("FAIL R10 mask got %h exp 0a00", mask); end
    n_chk++;
    ev(20, 2, 0, 1'b1); check("R6 R10 line2 -> 11");
    ev(21, 0, 0, 1'b1); check("R6 R10 lines0,2 share 11");
    ev(20, 2, 0, 1'b0); check("R6 line0 keeps 11");
    wr(4, 8'hA5); check("R7 low byte");

    // R8 unused selectors
    wr(6, 8'hFF); check("R8 sel6");
    wr(7, 8'h00); check("R8 sel7");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 7)
        ev($urandom_range(0, 63), $urandom_range(0, 31), $urandom_range(0, 3),
           1'($urandom_range(0, 1)));
      else
        wr($urandom_range(0, 7), $urandom_range(0, 255));
      check("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule